// File: doc/BRIEF.md
# Serial link frame synchronizer

This block sits behind the word decoder of one serial receive link. Every accepted input word carries a flag telling whether it is a control character or payload. Any control word is treated as a fill. Payload arrives in frames of seven consecutive data words with no header word. Frame boundaries are therefore recovered only from fills: the first data word after a fill opens a frame. Once a frame is open, every seventh data word closes it, and the next data word opens a new one.

Each payload word is passed on with its slot index inside the frame and a start-of-frame marker. After reset the block is out of sync and discards payload until it sees a fill. A fill that cuts into a half-received frame drops the partial frame and raises a frame error. A watchdog counts data words since the last fill and raises a missing-fill error when that count grows too long. A bank of ten sticky error flags holds these two real conditions. Every flag in the bank can also be raised on demand through a force mask, so error-handling software can be tested with no real fault present.

Top module: `link_frame_sync`

## Requirements
- R1: While reset is applied and after it is released with no input, `out_valid` is 0, `in_sync` is 0 and `err_flags` is all zero.
- R2: Data words (`in_ctrl`=0) received before the first fill are discarded: `out_valid` stays 0. The first valid control word sets `in_sync` to 1, and it stays 1 until reset.
- R3: In sync, each accepted data word appears on `out_word` unchanged on the cycle after it is accepted, with `out_valid`=1. `out_slot` counts 0 to 6 through a frame, and `out_sof`=1 only on slot 0.
- R4: A data word that follows the seventh word of a frame starts a new frame at slot 0 without any fill in between.
- R5: A fill that arrives after 1 to 6 words of a frame sets `err_flags` bit 0 (frame error). It drops the partial frame, so the next data word is output at slot 0, and `in_sync` stays 1.
- R6: Fills between complete frames produce no output and set no error.
- R7: A data word accepted in sync when 100 (FILL_LIMIT) data words have already arrived since the last fill sets `err_flags` bit 1 (missing fill). Any fill restarts that count.
- R8: When `force_err[i]` is 1 on a cycle, `err_flags[i]` is 1 from the next cycle, for each of the ten bits.
- R9: Error flags are sticky. A 1 on `err_clr[i]` clears bit i on the next cycle, unless that bit is being set on the same cycle, in which case the set wins.
- R10: A cycle with `in_valid`=0 produces `out_valid`=0 and changes neither the slot position nor the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 32 | Decoded link word |
| in_ctrl | input | 1 | 1 = control character (fill), 0 = data |
| err_clr | input | 10 | Write-one-to-clear pulses for the error flags |
| force_err | input | 10 | Force mask; a 1 raises the matching flag |
| out_word | output | 32 | Framed data word |
| out_slot | output | 3 | Position of the word in its frame, 0 to 6 |
| out_sof | output | 1 | Start of frame (slot 0) |
| out_valid | output | 1 | Output word qualifier |
| in_sync | output | 1 | Frame alignment acquired |
| err_flags | output | 10 | Sticky flags: bit 0 frame error, bit 1 missing fill, bits 2 to 9 force only |

## Verification
The missing-fill condition is the hardest case to reach from the ports. It needs over a hundred data words in sync with no control word, and the alignment and wrapping of the slot counter must stay right the whole time. The stimulus sends one fill and then exactly 100 data words, checks that the flag is still clear, and then sends the 101st word. A behavioural reference model tracks sync, slot and count as plain integers and is compared against every output on every clock. This also covers the slot wrap over more than fourteen back-to-back frames.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int ERR_BITS   = 10;
  localparam int ERR_FRAME  = 0;
  localparam int ERR_NOFILL = 1;
endpackage

// File: rtl/lfs_slot_tracker.sv
module lfs_slot_tracker #(
  parameter int WORD_W    = 32,
  parameter int FRAME_LEN = 7,
  localparam int SW       = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ctrl,
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] out_word,
  output logic [SW-1:0]     out_slot,
  output logic              out_sof,
  output logic              out_valid,
  output logic              sync,
  output logic              frame_err_evt
);
  localparam logic [SW-1:0] LAST = SW'(FRAME_LEN - 1);

  logic          sync_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          accept;

  assign accept        = in_valid && !in_ctrl && sync;
  assign frame_err_evt = in_valid && in_ctrl && (slot_q != '0);

  always_comb begin
    sync_d = sync;
    slot_d = slot_q;
    if (in_valid && in_ctrl) begin
      sync_d = 1'b1;
      slot_d = '0;
    end else if (accept) begin
      slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 1'b0;
      slot_q    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_slot  <= '0;
      out_sof   <= 1'b0;
    end else begin
      sync      <= sync_d;
      slot_q    <= slot_d;
      out_valid <= accept;
      if (accept) begin
        out_word <= in_word;
        out_slot <= slot_q;
        out_sof  <= (slot_q == '0);
      end
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && slot_q == LAST) |=> (slot_q == '0)) else $error("wrap"); // R4
  AST_FILL_REALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl) |=> (sync && slot_q == '0)) else $error("realign"); // R5
  AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(slot_q))) else $error("idle"); // R10
endmodule

// File: rtl/lfs_fill_watch.sv
module lfs_fill_watch #(
  parameter int FILL_LIMIT = 100,
  localparam int CW        = $clog2(FILL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_ctrl,
  input  logic sync,
  output logic nofill_evt
);
  localparam logic [CW-1:0] LIM = CW'(FILL_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          data_in_sync;

  assign data_in_sync = in_valid && !in_ctrl && sync;
  assign nofill_evt   = data_in_sync && (cnt_q == LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid && in_ctrl)
      cnt_d = '0;
    else if (data_in_sync && cnt_q != LIM)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_FILL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl) |=> (cnt_q == '0)) else $error("fill count"); // R7
  AST_COUNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q)) else $error("count idle"); // R10
endmodule

// File: rtl/lfs_err_bank.sv
module lfs_err_bank #(
  parameter int N = lfs_pkg::ERR_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] force_mask,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic set_i, next_i;
    assign set_i  = evt[i] | force_mask[i];
    assign next_i = set_i | (flags[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= next_i;
    end

    AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      force_mask[i] |=> flags[i]) else $error("force"); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]) else $error("sticky"); // R9
  end
endmodule

// File: rtl/link_frame_sync.sv
module link_frame_sync #(
  parameter int WORD_W     = 32,
  parameter int FRAME_LEN  = 7,
  parameter int FILL_LIMIT = 100,
  parameter int NUM_ERR    = lfs_pkg::ERR_BITS,
  localparam int SW        = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               in_ctrl,
  input  logic [NUM_ERR-1:0] err_clr,
  input  logic [NUM_ERR-1:0] force_err,
  output logic [WORD_W-1:0]  out_word,
  output logic [SW-1:0]      out_slot,
  output logic               out_sof,
  output logic               out_valid,
  output logic               in_sync,
  output logic [NUM_ERR-1:0] err_flags
);
  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  logic               frame_err_evt, nofill_evt;
  logic [NUM_ERR-1:0] evt_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  lfs_slot_tracker #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_track (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_word(in_word), .out_word(out_word), .out_slot(out_slot),
    .out_sof(out_sof), .out_valid(out_valid), .sync(in_sync),
    .frame_err_evt(frame_err_evt)
  );

  lfs_fill_watch #(.FILL_LIMIT(FILL_LIMIT)) u_watch (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .sync(in_sync), .nofill_evt(nofill_evt)
  );

  always_comb begin
    evt_vec = '0;
    evt_vec[lfs_pkg::ERR_FRAME]  = frame_err_evt;
    evt_vec[lfs_pkg::ERR_NOFILL] = nofill_evt;
  end

  lfs_err_bank #(.N(NUM_ERR)) u_err (
    .clk(clk), .rst_n(rst_n_s), .evt(evt_vec), .force_mask(force_err),
    .clr(err_clr), .flags(err_flags)
  );

  AST_VALID_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> in_sync) else $error("valid unsynced"); // R2
  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_sync |=> in_sync) else $error("sync lost"); // R2
  AST_SOF_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_sof |-> (out_slot == '0)) else $error("sof slot"); // R3
endmodule

// File: tb/sim_link_frame_sync.sv
module sim_link_frame_sync;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ctrl;
  logic [31:0] in_word;
  logic [9:0]  err_clr, force_err;
  logic [31:0] out_word;
  logic [2:0]  out_slot;
  logic        out_sof, out_valid, in_sync;
  logic [9:0]  err_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int       m_sync, m_slot, m_fcnt;
  bit [9:0] m_err;
  bit       e_valid, e_sof;
  bit [31:0] e_word;
  int       e_slot;
  int       wcount = 0;

  always #2 clk = ~clk;

  link_frame_sync u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ctrl(in_ctrl), .err_clr(err_clr), .force_err(force_err),
    .out_word(out_word), .out_slot(out_slot), .out_sof(out_sof),
    .out_valid(out_valid), .in_sync(in_sync), .err_flags(err_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit c, input bit [9:0] clr, input bit [9:0] frc);
    bit [9:0] set;
    in_valid = v; in_ctrl = c; err_clr = clr; force_err = frc;
    wcount++;
    in_word = 32'h5A00_0000 + wcount;
    @(posedge clk);
    set = frc;
    e_valid = 1'b0;
    if (v) begin
      if (c) begin
        if (m_slot != 0) set[0] = 1'b1;
        m_sync = 1; m_slot = 0; m_fcnt = 0;
      end else if (m_sync != 0) begin
        e_valid = 1'b1; e_word = in_word; e_slot = m_slot; e_sof = (m_slot == 0);
        m_slot = (m_slot == 6) ? 0 : m_slot + 1;
        if (m_fcnt == 100) set[1] = 1'b1;
        else m_fcnt++;
      end
    end
    m_err = set | (m_err & ~clr);
    @(negedge clk);
    chk("R2 R10 out_valid", 32'(out_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R3 out_word", out_word, e_word);
      chk("R3 R4 R5 out_slot", 32'(out_slot), 32'(e_slot));
      chk("R3 out_sof", 32'(out_sof), 32'(e_sof));
    end
    chk("R2 in_sync", 32'(in_sync), 32'(m_sync != 0));
    chk("R5 R7 R8 R9 err_flags", 32'(err_flags), 32'(m_err));
  endtask

  task automatic data(input int n);
    for (int i = 0; i < n; i++) step(1, 0, '0, '0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_ctrl = 0; in_word = '0; err_clr = '0; force_err = '0;
    m_sync = 0; m_slot = 0; m_fcnt = 0; m_err = '0;
    repeat (5) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_sync", 32'(in_sync), 0);
    chk("R1 err_flags", 32'(err_flags), 0);
    // R2: data before any fill is discarded
    data(3);
    step(0, 0, '0, '0);                 // R10 idle
    step(1, 1, '0, '0);                 // first fill
    chk("R2 synced", 32'(in_sync), 1);
    // R3 one frame, R4 back-to-back frame with idle gap inside
    data(4); step(0, 0, '0, '0); data(3);
    data(7);
    // R6 fills between frames
    step(1, 1, '0, '0); step(1, 1, '0, '0);
    chk("R6 no error", 32'(err_flags), 0);
    // R5 fill mid-frame
    data(3); step(1, 1, '0, '0);
    chk("R5 frame error bit0", 32'(err_flags[0]), 1);
    data(7);
    chk("R5 still synced", 32'(in_sync), 1);
    step(0, 0, '0, '0); step(0, 0, '0, '0);
    chk("R9 sticky bit0", 32'(err_flags[0]), 1);
    step(0, 0, 10'h001, '0);
    chk("R9 cleared bit0", 32'(err_flags[0]), 0);
    // R7 missing-fill watchdog
    step(1, 1, '0, '0);
    data(100);
    chk("R7 not yet", 32'(err_flags[1]), 0);
    data(1);
    chk("R7 missing fill bit1", 32'(err_flags[1]), 1);
    data(5);
    step(1, 1, 10'h003, '0);           // fill mid-frame sets bit0 while clear asked: set wins
    chk("R9 set wins bit0", 32'(err_flags[0]), 1);
    chk("R9 bit1 cleared", 32'(err_flags[1]), 0);
    // R8 forced errors, R9 set over clear
    step(0, 0, '0, 10'h3F4);
    chk("R8 forced", 32'(err_flags), 32'h3F5);
    step(0, 0, 10'h010, 10'h010);
    chk("R9 force beats clear", 32'(err_flags[4]), 1);
    step(0, 0, 10'h3FF, '0);
    chk("R9 all cleared", 32'(err_flags), 0);
    data(9);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule